// File: doc/BRIEF.md
# Dual-Bank Multiply-Accumulate Datapath

This block is the arithmetic core of a signal-processing engine. Each cycle it accepts one decoded operation. The central operation is a fused step that does four things at once. It reads one operand from the X data bank and one from the Y data bank, each through an address register used as a pointer. It multiplies the two signed 16-bit operands and adds the product into one of two 40-bit accumulators. It also post-increments both pointers. The two banks have separate ports, so both reads happen in the same cycle.

The datapath has two stages. In the first stage, the bank reads are issued and the pointers are updated. In the second stage, the multiply and the accumulator update happen. The second stage is a small state machine with four states:
- `EX_IDLE`: nothing to do.
- `EX_MAC`: accumulate.
- `EX_CLR`: clear the selected accumulator.
- `EX_READ`: produce a saturated read-out.

The state is reloaded on every clock from the incoming operation:
- a multiply-accumulate leads to `EX_MAC`;
- a clear leads to `EX_CLR`;
- a read leads to `EX_READ`;
- every other code leads to `EX_IDLE`.

Any state may move to any state. Other operations load a pointer with an immediate value or write an immediate word into either bank. Instruction fetch and sequencing sit outside the block.

Top module: `dsp_mac_core`

## Requirements
- R1: After reset, all eight pointers and both accumulators are zero, and `res_valid_o` is low.
- R2: Code 1 (MAC) adds the signed product X[ptr[src_a_i]] × Y[ptr[src_b_i]] into accumulator `acc_sel_i`. Select 0 is accumulator A and select 1 is accumulator B. The 32-bit product is sign-extended to 40 bits before the add, and the sum wraps modulo 2^40.
- R3: A MAC increments both named pointers by one, and each pointer wraps from 255 to 0.
- R4: When `src_a_i` equals `src_b_i`, a MAC increments that pointer exactly once.
- R5: MACs issued on consecutive cycles are each applied in issue order, at a rate of one per cycle.
- R6: Code 2 (CLR) sets the selected accumulator to zero and leaves the other accumulator unchanged.
- R7: Code 3 (LDPTR) writes `imm_i[7:0]` into pointer `src_a_i`, and the next operation sees the new value.
- R8: Code 4 (READ) raises `res_valid_o` for one cycle, two clocks after the operation is sampled. `res_data_o` then carries the selected accumulator saturated to the signed 32-bit range, reflecting every operation issued before the READ.
- R9: An accumulator keeps sums beyond the 32-bit range, so a later subtraction that brings it back in range reads out exactly.
- R10: Code 5 (WRX) writes `imm_i` into X, and code 6 (WRY) writes `imm_i` into Y. Both write at ptr[`src_a_i`] and then increment that pointer.
- R11: Codes 0 and 7 change no pointer, bank word or accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 3 | Operation code |
| acc_sel_i | input | 1 | Accumulator select (0 = A, 1 = B) |
| src_a_i | input | 3 | First pointer index (X side, write, load) |
| src_b_i | input | 3 | Second pointer index (Y side) |
| imm_i | input | 16 | Immediate word or pointer value |
| res_valid_o | output | 1 | Read result valid pulse |
| res_data_o | output | 32 | Saturated accumulator value |

## Verification
Pointers and accumulators can only be seen through a READ. A wrong pointer step therefore shows up as a wrong product, and a wrong accumulator shows up as wrong saturated data, but only at the next READ, two cycles after that READ is sampled. The sequence therefore issues a READ after every group of pointer or accumulator activity, including pointer wrap, a repeated pointer, sums beyond 32 bits and both saturation limits. A cycle-level reference compares every cycle, so a result that is early, late or spurious is caught on the cycle it appears.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    typedef enum logic [2:0] {
        OPC_NOP0  = 3'd0,
        OPC_MAC   = 3'd1,
        OPC_CLR   = 3'd2,
        OPC_LDPTR = 3'd3,
        OPC_READ  = 3'd4,
        OPC_WRX   = 3'd5,
        OPC_WRY   = 3'd6,
        OPC_NOP7  = 3'd7
    } opc_t;

    typedef enum logic [1:0] {
        EX_IDLE = 2'd0,
        EX_MAC  = 2'd1,
        EX_CLR  = 2'd2,
        EX_READ = 2'd3
    } ex_state_t;

endpackage

// File: rtl/dmac_bank.sv
module dmac_bank #(
    parameter int DW = 16,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/dmac_ptrfile.sv
module dmac_ptrfile #(
    parameter int NREG = 8,
    parameter int AW   = 8,
    localparam int IW  = $clog2(NREG)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ld_en,
    input  logic [IW-1:0]      ld_idx,
    input  logic [AW-1:0]      ld_val,
    input  logic               inc_a_en,
    input  logic [IW-1:0]      idx_a,
    input  logic               inc_b_en,
    input  logic [IW-1:0]      idx_b,
    output logic [AW-1:0]      ptr_a,
    output logic [AW-1:0]      ptr_b,
    output logic [NREG*AW-1:0] ptr_flat
);
    logic [AW-1:0] regs [NREG];

    for (genvar k = 0; k < NREG; k++) begin : g_reg
        logic hit_ld;
        logic hit_inc;
        assign hit_ld  = ld_en && (ld_idx == IW'(k));
        // one increment even when both sources name this register
        assign hit_inc = (inc_a_en && (idx_a == IW'(k))) ||
                         (inc_b_en && (idx_b == IW'(k)));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[k] <= '0;
            end else if (hit_ld) begin
                regs[k] <= ld_val;
            end else if (hit_inc) begin
                regs[k] <= regs[k] + AW'(1);
            end
        end

        assign ptr_flat[k*AW +: AW] = regs[k];
    end

    assign ptr_a = regs[idx_a];
    assign ptr_b = regs[idx_b];
endmodule

// File: rtl/dmac_accum.sv
module dmac_accum
    import dmac_pkg::*;
#(
    parameter int DW   = 16,
    parameter int ACCW = 40,
    parameter int OUTW = 32,
    parameter int NACC = 2,
    localparam int SW  = (NACC > 1) ? $clog2(NACC) : 1,
    localparam int PW  = 2 * DW,
    localparam int GW  = ACCW - PW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  ex_state_t          ex_state,
    input  logic [SW-1:0]      sel,
    input  logic [DW-1:0]      x_data,
    input  logic [DW-1:0]      y_data,
    output logic [NACC*ACCW-1:0] acc_flat,
    output logic               res_valid,
    output logic [OUTW-1:0]    res_data
);
    localparam logic [OUTW-1:0] SAT_MAX = {1'b0, {(OUTW-1){1'b1}}};
    localparam logic [OUTW-1:0] SAT_MIN = {1'b1, {(OUTW-1){1'b0}}};

    logic signed [PW-1:0]   product;
    logic        [ACCW-1:0] product_ext;
    logic        [ACCW-1:0] acc [NACC];
    logic        [ACCW-1:0] acc_pick;
    logic        [OUTW-1:0] sat_val;
    logic                   in_range;

    assign product     = $signed(x_data) * $signed(y_data);
    assign product_ext = {{GW{product[PW-1]}}, product};

    for (genvar k = 0; k < NACC; k++) begin : g_acc
        logic mine;
        assign mine = (sel == SW'(k));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                acc[k] <= '0;
            end else begin
                unique case (ex_state)
                    EX_MAC:  if (mine) acc[k] <= acc[k] + product_ext;
                    EX_CLR:  if (mine) acc[k] <= '0;
                    default: ;
                endcase
            end
        end

        assign acc_flat[k*ACCW +: ACCW] = acc[k];
    end

    assign acc_pick = acc[sel];
    // in range when every bit above the output sign bit matches it
    assign in_range = (acc_pick[ACCW-1:OUTW-1] == '0) ||
                      (acc_pick[ACCW-1:OUTW-1] == '1);

    always_comb begin
        if (in_range) begin
            sat_val = acc_pick[OUTW-1:0];
        end else if (acc_pick[ACCW-1]) begin
            sat_val = SAT_MIN;
        end else begin
            sat_val = SAT_MAX;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_data  <= '0;
        end else begin
            res_valid <= (ex_state == EX_READ);
            if (ex_state == EX_READ) begin
                res_data <= sat_val;
            end
        end
    end
endmodule

// File: rtl/dsp_mac_core.sv
module dsp_mac_core
    import dmac_pkg::*;
#(
    parameter int DW   = 16,
    parameter int AW   = 8,
    parameter int NAR  = 8,
    parameter int ACCW = 40,
    parameter int OUTW = 32,
    parameter int NACC = 2,
    localparam int IW  = $clog2(NAR),
    localparam int SW  = (NACC > 1) ? $clog2(NACC) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2:0]      op_i,
    input  logic [SW-1:0]   acc_sel_i,
    input  logic [IW-1:0]   src_a_i,
    input  logic [IW-1:0]   src_b_i,
    input  logic [DW-1:0]   imm_i,
    output logic            res_valid_o,
    output logic [OUTW-1:0] res_data_o
);
    ex_state_t ex_q, ex_next;
    logic [SW-1:0] sel_q;

    logic ld_en, inc_a_en, inc_b_en, x_we, y_we;
    logic [AW-1:0] ptr_a, ptr_b;
    logic [NAR*AW-1:0] ptr_flat;
    logic [NACC*ACCW-1:0] acc_flat;
    logic [DW-1:0] x_rd, y_rd;

    // stage 1: decode into pointer, bank and next-state controls
    always_comb begin
        ld_en    = 1'b0;
        inc_a_en = 1'b0;
        inc_b_en = 1'b0;
        x_we     = 1'b0;
        y_we     = 1'b0;
        ex_next  = EX_IDLE;
        unique case (opc_t'(op_i))
            OPC_MAC: begin
                inc_a_en = 1'b1;
                inc_b_en = 1'b1;
                ex_next  = EX_MAC;
            end
            OPC_CLR:   ex_next = EX_CLR;
            OPC_LDPTR: ld_en = 1'b1;
            OPC_READ:  ex_next = EX_READ;
            OPC_WRX: begin
                x_we     = 1'b1;
                inc_a_en = 1'b1;
            end
            OPC_WRY: begin
                y_we     = 1'b1;
                inc_a_en = 1'b1;
            end
            default: ;
        endcase
    end

    // execute-stage state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ex_q  <= EX_IDLE;
            sel_q <= '0;
        end else begin
            ex_q  <= ex_next;
            sel_q <= acc_sel_i;
        end
    end

    dmac_ptrfile #(.NREG(NAR), .AW(AW)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_en    (ld_en),
        .ld_idx   (src_a_i),
        .ld_val   (imm_i[AW-1:0]),
        .inc_a_en (inc_a_en),
        .idx_a    (src_a_i),
        .inc_b_en (inc_b_en),
        .idx_b    (src_b_i),
        .ptr_a    (ptr_a),
        .ptr_b    (ptr_b),
        .ptr_flat (ptr_flat)
    );

    dmac_bank #(.DW(DW), .AW(AW)) u_xbank (
        .clk   (clk),
        .we    (x_we),
        .waddr (ptr_a),
        .wdata (imm_i),
        .raddr (ptr_a),
        .rdata (x_rd)
    );

    dmac_bank #(.DW(DW), .AW(AW)) u_ybank (
        .clk   (clk),
        .we    (y_we),
        .waddr (ptr_a),
        .wdata (imm_i),
        .raddr (ptr_b),
        .rdata (y_rd)
    );

    // stage 2: outputs and accumulators
    dmac_accum #(.DW(DW), .ACCW(ACCW), .OUTW(OUTW), .NACC(NACC)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .ex_state  (ex_q),
        .sel       (sel_q),
        .x_data    (x_rd),
        .y_data    (y_rd),
        .acc_flat  (acc_flat),
        .res_valid (res_valid_o),
        .res_data  (res_data_o)
    );
endmodule

// File: rtl/dmac_checker.sv
module dmac_checker #(
    parameter int AW   = 8,
    parameter int NAR  = 8,
    parameter int ACCW = 40,
    parameter int NACC = 2,
    localparam int IW  = $clog2(NAR)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [2:0]           op_i,
    input logic                 acc_sel_i,
    input logic [IW-1:0]        src_a_i,
    input logic [IW-1:0]        src_b_i,
    input logic [15:0]          imm_i,
    input logic                 res_valid_o,
    input logic [NAR*AW-1:0]    ptr_flat,
    input logic [NACC*ACCW-1:0] acc_flat
);
    logic [AW-1:0] ptrs [NAR];
    for (genvar k = 0; k < NAR; k++) begin : g_unpack
        assign ptrs[k] = ptr_flat[k*AW +: AW];
    end

    logic [IW-1:0] last_a;
    always_ff @(posedge clk) last_a <= src_a_i;

    logic [AW-1:0] ptr_now, ptr_last;
    logic [ACCW-1:0] acc_a, acc_b;
    assign ptr_now  = ptrs[src_a_i];
    assign ptr_last = ptrs[last_a];
    assign acc_a    = acc_flat[ACCW-1:0];
    assign acc_b    = acc_flat[2*ACCW-1:ACCW];

    AST_LDPTR_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd3) |=> (ptr_last == $past(imm_i[AW-1:0]))); // R7

    AST_MAC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd1 && src_a_i != src_b_i) |=> (ptr_last == $past(ptr_now) + AW'(1))); // R3

    AST_SAME_PTR_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd1 && src_a_i == src_b_i) |=> (ptr_last == $past(ptr_now) + AW'(1))); // R4

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd4) |-> ##2 res_valid_o); // R8

    AST_CLR_A_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd2 && !acc_sel_i) |-> ##2 (acc_a == '0)); // R6

    AST_CLR_B_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd2 && acc_sel_i) |-> ##2 (acc_b == '0)); // R6
endmodule

bind dsp_mac_core dmac_checker #(.AW(AW), .NAR(NAR), .ACCW(ACCW), .NACC(NACC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_i        (op_i),
    .acc_sel_i   (acc_sel_i),
    .src_a_i     (src_a_i),
    .src_b_i     (src_b_i),
    .imm_i       (imm_i),
    .res_valid_o (res_valid_o),
    .ptr_flat    (ptr_flat),
    .acc_flat    (acc_flat)
);

// File: tb/sim_dsp_mac_core.sv
module sim_dsp_mac_core;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0]  op_i = '0;
    logic        acc_sel_i = 1'b0;
    logic [2:0]  src_a_i = '0;
    logic [2:0]  src_b_i = '0;
    logic [15:0] imm_i = '0;
    logic        res_valid_o;
    logic [31:0] res_data_o;

    always #5 clk = ~clk;

    dsp_mac_core u0 (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .acc_sel_i(acc_sel_i),
        .src_a_i(src_a_i), .src_b_i(src_b_i), .imm_i(imm_i),
        .res_valid_o(res_valid_o), .res_data_o(res_data_o)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // behavioural reference state
    int     xm [256];
    int     ym [256];
    int     ptr [8];
    longint acc [2];

    // two-slot expectation pipeline
    bit        pv [2];
    bit [31:0] pd [2];
    string     pt [2];

    function automatic longint wrap40(input longint v);
        longint m;
        m = v & ((longint'(1) << 40) - 1);
        if (m[39]) m = m - (longint'(1) << 40);
        return m;
    endfunction

    function automatic bit [31:0] sat32(input longint v);
        if (v > 64'sd2147483647) return 32'h7fffffff;
        if (v < -64'sd2147483648) return 32'h80000000;
        return v[31:0];
    endfunction

    function automatic longint s16(input int v);
        return longint'($signed(v[15:0]));
    endfunction

    task automatic compare_out(input string tag);
        checks++;
        if (res_valid_o !== pv[1]) begin
            errors++;
            $display("FAIL %s valid actual=%0b expected=%0b", tag, res_valid_o, pv[1]);
        end else if (pv[1] && res_data_o !== pd[1]) begin
            errors++;
            $display("FAIL %s data actual=%08h expected=%08h", tag, res_data_o, pd[1]);
        end
    endtask

    task automatic step(input int op, input int sel, input int a, input int b,
                        input int imm, input string tag);
        @(negedge clk);
        compare_out(pt[1]);
        pv[1] = pv[0]; pd[1] = pd[0]; pt[1] = pt[0];
        op_i = op[2:0]; acc_sel_i = sel[0]; src_a_i = a[2:0]; src_b_i = b[2:0];
        imm_i = imm[15:0];
        pv[0] = 0; pd[0] = '0; pt[0] = tag;
        case (op)
            1: begin
                acc[sel] = wrap40(acc[sel] + s16(xm[ptr[a]]) * s16(ym[ptr[b]]));
                ptr[a] = (ptr[a] + 1) % 256;
                if (b != a) ptr[b] = (ptr[b] + 1) % 256;
            end
            2: acc[sel] = 0;
            3: ptr[a] = imm & 255;
            4: begin pv[0] = 1; pd[0] = sat32(acc[sel]); end
            5: begin xm[ptr[a]] = imm & 16'hffff; ptr[a] = (ptr[a] + 1) % 256; end
            6: begin ym[ptr[a]] = imm & 16'hffff; ptr[a] = (ptr[a] + 1) % 256; end
            default: ;
        endcase
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        foreach (xm[k]) begin xm[k] = 0; ym[k] = 0; end
        foreach (ptr[k]) ptr[k] = 0;
        acc[0] = 0; acc[1] = 0;
        pv[0] = 0; pv[1] = 0; pd[0] = '0; pd[1] = '0; pt[0] = "R1"; pt[1] = "R1";

        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (res_valid_o !== 1'b0) begin
            errors++;
            $display("FAIL R1 valid in reset actual=%0b expected=0", res_valid_o);
        end
        rst_n = 1'b1;

        // R1: reset contents
        step(4, 0, 0, 0, 0, "R1");
        step(4, 1, 0, 0, 0, "R1");

        // R10: fill banks, pointer 0 and 1 from zero; R7 reload
        for (int k = 0; k < 8; k++) step(5, 0, 0, 0, (k + 1) * 300 - 900, "R10");
        for (int k = 0; k < 8; k++) step(6, 0, 1, 0, 1000 - k * 450, "R10");
        step(3, 0, 2, 0, 0, "R7");
        step(3, 0, 3, 0, 0, "R7");

        // R2/R5: back-to-back MACs into A
        for (int k = 0; k < 6; k++) step(1, 0, 2, 3, 0, "R5");
        step(4, 0, 0, 0, 0, "R2");
        // R2: B independent of A
        step(3, 0, 2, 0, 5, "R7");
        step(1, 1, 2, 3, 0, "R2");
        step(1, 1, 3, 2, 0, "R2");
        step(4, 1, 0, 0, 0, "R2");
        step(4, 0, 0, 0, 0, "R2");

        // R4: same pointer on both sides
        step(3, 0, 4, 0, 1, "R7");
        step(1, 1, 4, 4, 0, "R4");
        step(1, 1, 4, 4, 0, "R4");
        step(1, 1, 4, 4, 0, "R4");
        step(4, 1, 0, 0, 0, "R4");

        // R6: clear A only
        step(2, 0, 0, 0, 0, "R6");
        step(4, 0, 0, 0, 0, "R6");
        step(4, 1, 0, 0, 0, "R6");

        // R8/R9: saturation and guard bits on A
        step(3, 0, 0, 0, 16, "R7");
        step(3, 0, 1, 0, 16, "R7");
        for (int k = 0; k < 5; k++) step(5, 0, 0, 0, 16'h7fff, "R10");
        for (int k = 0; k < 8; k++) step(5, 0, 0, 0, 16'h8000, "R10");
        for (int k = 0; k < 13; k++) step(6, 0, 1, 0, 16'h7fff, "R10");
        step(3, 0, 5, 0, 16, "R7");
        step(3, 0, 6, 0, 16, "R7");
        for (int k = 0; k < 5; k++) step(1, 0, 5, 6, 0, "R9");
        step(4, 0, 0, 0, 0, "R8");
        for (int k = 0; k < 5; k++) step(1, 0, 5, 6, 0, "R9");
        step(4, 0, 0, 0, 0, "R9");
        for (int k = 0; k < 3; k++) step(1, 0, 5, 6, 0, "R8");
        step(4, 0, 0, 0, 0, "R8");

        // R3: pointer wrap at 255
        step(3, 0, 7, 0, 255, "R7");
        step(3, 0, 0, 0, 255, "R7");
        step(5, 0, 7, 0, 16'h0123, "R10");
        step(6, 0, 0, 0, 16'hff00, "R10");
        step(3, 0, 7, 0, 255, "R7");
        step(3, 0, 0, 0, 255, "R7");
        step(2, 1, 0, 0, 0, "R6");
        step(1, 1, 7, 0, 0, "R3");
        step(1, 1, 7, 0, 0, "R3");
        step(1, 1, 7, 0, 0, "R3");
        step(4, 1, 0, 0, 0, "R3");

        // R11: reserved codes change nothing
        step(0, 1, 7, 0, 16'h00aa, "R11");
        step(7, 1, 7, 0, 16'h0055, "R11");
        step(7, 0, 0, 0, 16'h00ff, "R11");
        step(1, 1, 7, 0, 0, "R11");
        step(4, 1, 0, 0, 0, "R11");
        step(4, 0, 0, 0, 0, "R11");

        for (int k = 0; k < 3; k++) step(0, 0, 0, 0, 0, "R8");
        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end
endmodule